// File: doc/BRIEF.md
# Light Measurement Cycle Sequencer

This block steps a light sensor front end through its measurement cycle. After power-up it waits in a low-power Sleep state. It then enters Idle and, once light sensing is enabled, loops through three phases: a settling phase of one base step, an integration phase of a programmed number of steps, and an optional pause phase. The pause can be stretched twelvefold for slow polling. Every duration is counted in base-step ticks. An outside divider supplies these ticks as one-cycle pulses, one per 2.73 ms step.

The sequencer issues three kinds of strobe. One starts the converter. One marks the end of integration and latches the result. One forwards an interrupt when the external threshold logic flags the finished result. When the interrupt arrives and the sleep-after-interrupt option is set, the block parks in Sleep. It stays there until the host bus signals a start condition. The current state is always visible on an output so the host can read it.

Top module: `als_cycle_seq`

## Requirements
- R1: Synchronous reset puts the block in Sleep and holds all strobes low. The state output uses the codes Sleep=0, Idle=1, Init=2, Integrate=3 and Pause=4.
- R2: When `pwr_on_i` is low, the state is Sleep on the next cycle from any state, with no strobes and all step counters cleared. When `pwr_on_i` is high and the block is not parked, Sleep moves to Idle on the next cycle.
- R3: From Idle with `als_en_i` high, the block enters Init on the next cycle. Init ends on the first tick that arrives after entry.
- R4: Integrate lasts exactly N ticks, where N is `integ_steps_i` captured on entry and a value of 0 means 256. `adc_start_o` pulses in the first cycle of Integrate.
- R5: On each normal exit from Integrate, `integ_done_o` and `latch_o` pulse for one cycle, in the first cycle of the next state. `int_o` pulses in that same cycle if `int_hit_i` was high on the exit edge.
- R6: After Integrate, the block goes to Pause if `wait_en_i` is high and otherwise straight back to Init. After Pause it returns to Init.
- R7: Pause lasts M ticks when `long_wait_i` is low and 12*M ticks when it is high. M is `wait_steps_i` captured on entry, and 0 means 256.
- R8: If `int_hit_i` and `sleep_on_int_i` are both high on the exit from Integrate, the block goes to Sleep and remains there, even with power on, until a one-cycle `bus_start_i` pulse moves it to Idle.
- R9: If `als_en_i` is low at the end of Init, Integrate or Pause, the next state is Idle. An interrupt park takes priority over this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per base step |
| pwr_on_i | input | 1 | Power-on enable bit |
| als_en_i | input | 1 | Light measurement enable bit |
| wait_en_i | input | 1 | Pause phase enable bit |
| sleep_on_int_i | input | 1 | Park in Sleep after an interrupt |
| long_wait_i | input | 1 | Multiply each pause step by 12 |
| integ_steps_i | input | STEP_W | Integration length in steps (0 = 256) |
| wait_steps_i | input | STEP_W | Pause length in steps (0 = 256) |
| int_hit_i | input | 1 | Threshold logic flags the current result |
| bus_start_i | input | 1 | One-cycle pulse on a host bus start condition |
| state_o | output | 3 | Current state code |
| adc_start_o | output | 1 | Converter start strobe |
| integ_done_o | output | 1 | End-of-integration strobe |
| latch_o | output | 1 | Result latch strobe |
| int_o | output | 1 | Interrupt strobe |

## Verification
The assertions assume the following about the inputs. `tick_i` is a single-cycle pulse. `bus_start_i` is a one-cycle strobe. Reset is held for several cycles, so every `$past` term refers to a defined state. The step fields may change at any time, because they are read only at state entry. In the stimulus, ticks arrive every second cycle and all inputs change on the falling clock edge. Enable bits are changed only after the scoreboard has seen the state it was waiting for, so every transition the bench predicts falls on a known tick boundary.

// File: rtl/als_seq_pkg.sv
// Package: shared state encoding and default sizes for the light cycle sequencer.
// Assumes: the state codes are visible to software and must stay fixed.
package als_seq_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_INIT  = 3'd2,
        ST_INTEG = 3'd3,
        ST_PAUSE = 3'd4
    } seq_state_e;

    localparam int DEF_STEP_W    = 8;
    localparam int DEF_LONG_MULT = 12;

endpackage

// File: rtl/als_step_timer.sv
// Step timer: counts base ticks for one timed phase.
// A load captures the step count (0 means 2**STEP_W) and whether each step
// spans LONG_MULT ticks. While run_i is high, expire_o flags the tick that
// finishes the last step. Assumes load_i and clear_i are never high together
// with a tick that should count, and that a load occurs on every phase entry.
module als_step_timer #(
    parameter int STEP_W    = 8,
    parameter int LONG_MULT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [STEP_W-1:0] steps_i,
    input  logic              long_i,
    input  logic              run_i,
    input  logic              tick_i,
    output logic              expire_o
);
    localparam int CNT_W = STEP_W + 1;
    localparam int SUB_W = (LONG_MULT > 1) ? $clog2(LONG_MULT) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << STEP_W;
    localparam logic [SUB_W-1:0] SUB_TOP  = SUB_W'(LONG_MULT - 1);

    logic [CNT_W-1:0] step_q;
    logic [SUB_W-1:0] sub_q;
    logic             long_q;
    logic             sub_zero;

    assign sub_zero = (sub_q == '0);
    assign expire_o = run_i && tick_i && sub_zero && (step_q == CNT_W'(1));

    // Step counter: load on phase entry, count down one step per finished sub-count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            step_q <= '0;
            long_q <= 1'b0;
        end else if (load_i) begin
            step_q <= (steps_i == '0) ? FULL_CNT : CNT_W'(steps_i);
            long_q <= long_i;
        end else if (run_i && tick_i && sub_zero && (step_q != CNT_W'(1))) begin
            step_q <= step_q - CNT_W'(1);
        end
    end

    generate
        if (LONG_MULT > 1) begin : g_sub
            // Sub-counter: stretches each step to LONG_MULT ticks in long mode.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i) begin
                    sub_q <= '0;
                end else if (load_i) begin
                    sub_q <= long_i ? SUB_TOP : '0;
                end else if (run_i && tick_i) begin
                    if (sub_zero) begin
                        sub_q <= long_q ? SUB_TOP : '0;
                    end else begin
                        sub_q <= sub_q - SUB_W'(1);
                    end
                end
            end
        end else begin : g_nosub
            assign sub_q = '0;
        end
    endgenerate

    AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (step_q != '0)); // R4
    AST_SHORT_NO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_q) |-> sub_zero); // R7

endmodule

// File: rtl/als_seq_fsm.sv
// Cycle controller: chooses the next phase, loads the step timer on every
// timed entry and produces the registered strobes. Assumes expire_i comes
// from a timer loaded by load_o, and bus_start_i is a one-cycle pulse.
module als_seq_fsm
    import als_seq_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pwr_on_i,
    input  logic              als_en_i,
    input  logic              wait_en_i,
    input  logic              sleep_on_int_i,
    input  logic              long_wait_i,
    input  logic [STEP_W-1:0] integ_steps_i,
    input  logic [STEP_W-1:0] wait_steps_i,
    input  logic              int_hit_i,
    input  logic              bus_start_i,
    input  logic              expire_i,
    output seq_state_e        state_o,
    output logic              run_o,
    output logic              load_o,
    output logic [STEP_W-1:0] load_steps_o,
    output logic              load_long_o,
    output logic              adc_start_o,
    output logic              done_o,
    output logic              latch_o,
    output logic              int_o
);
    seq_state_e state_q, nxt;
    logic       parked_q;
    logic       exit_integ;
    logic       go_park;

    assign state_o = state_q;
    assign run_o   = (state_q == ST_INIT) || (state_q == ST_INTEG) || (state_q == ST_PAUSE);

    // Next-state choice and timer load selection.
    always_comb begin
        nxt          = state_q;
        load_o       = 1'b0;
        load_steps_o = STEP_W'(1);
        load_long_o  = 1'b0;
        exit_integ   = 1'b0;
        go_park      = 1'b0;
        case (state_q)
            ST_SLEEP: begin
                if (pwr_on_i && (!parked_q || bus_start_i)) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (als_en_i) begin
                    nxt    = ST_INIT;
                    load_o = 1'b1;
                end
            end
            ST_INIT: begin
                if (expire_i) begin
                    if (!als_en_i) begin
                        nxt = ST_IDLE;
                    end else begin
                        nxt          = ST_INTEG;
                        load_o       = 1'b1;
                        load_steps_o = integ_steps_i;
                    end
                end
            end
            ST_INTEG: begin
                if (expire_i) begin
                    exit_integ = 1'b1;
                    if (int_hit_i && sleep_on_int_i) begin
                        nxt     = ST_SLEEP;
                        go_park = 1'b1;
                    end else if (!als_en_i) begin
                        nxt = ST_IDLE;
                    end else if (wait_en_i) begin
                        nxt          = ST_PAUSE;
                        load_o       = 1'b1;
                        load_steps_o = wait_steps_i;
                        load_long_o  = long_wait_i;
                    end else begin
                        nxt    = ST_INIT;
                        load_o = 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (expire_i) begin
                    if (!als_en_i) begin
                        nxt = ST_IDLE;
                    end else begin
                        nxt    = ST_INIT;
                        load_o = 1'b1;
                    end
                end
            end
            default: nxt = ST_SLEEP;
        endcase
        if (!pwr_on_i) begin
            nxt        = ST_SLEEP;
            load_o     = 1'b0;
            exit_integ = 1'b0;
            go_park    = 1'b0;
        end
    end

    // State register and interrupt-park flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_SLEEP;
            parked_q <= 1'b0;
        end else begin
            state_q <= nxt;
            if (!pwr_on_i) begin
                parked_q <= 1'b0;
            end else if (go_park) begin
                parked_q <= 1'b1;
            end else if ((state_q == ST_SLEEP) && (nxt == ST_IDLE)) begin
                parked_q <= 1'b0;
            end
        end
    end

    // Registered strobes, each high for one cycle after its event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_start_o <= 1'b0;
            done_o      <= 1'b0;
            latch_o     <= 1'b0;
            int_o       <= 1'b0;
        end else begin
            adc_start_o <= (nxt == ST_INTEG) && (state_q != ST_INTEG);
            done_o      <= exit_integ;
            latch_o     <= exit_integ;
            int_o       <= exit_integ && int_hit_i;
        end
    end

    AST_OFF_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on_i) |=> (state_q == ST_SLEEP)); // R2
    AST_INIT_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_INIT) && ($past(state_q) == ST_INIT) && tick_i) |=> (state_q != ST_INIT)); // R3
    AST_LATCH_AFTER_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> ($past(state_q) == ST_INTEG)); // R5
    AST_PAUSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PAUSE) && ($past(state_q) != ST_PAUSE)) |-> $past(wait_en_i)); // R6
    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SLEEP) && parked_q && !bus_start_i) |=> (state_q == ST_SLEEP)); // R8

endmodule

// File: rtl/als_cycle_seq.sv
// Top of the light measurement cycle sequencer: joins the phase controller
// to its step timer. Assumes tick_i is a one-cycle pulse per base step and
// that the converter and threshold logic sit outside this block.
module als_cycle_seq
    import als_seq_pkg::*;
#(
    parameter int STEP_W    = DEF_STEP_W,
    parameter int LONG_MULT = DEF_LONG_MULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pwr_on_i,
    input  logic              als_en_i,
    input  logic              wait_en_i,
    input  logic              sleep_on_int_i,
    input  logic              long_wait_i,
    input  logic [STEP_W-1:0] integ_steps_i,
    input  logic [STEP_W-1:0] wait_steps_i,
    input  logic              int_hit_i,
    input  logic              bus_start_i,
    output logic [2:0]        state_o,
    output logic              adc_start_o,
    output logic              integ_done_o,
    output logic              latch_o,
    output logic              int_o
);
    seq_state_e        state;
    logic              run, load, load_long, expire;
    logic [STEP_W-1:0] load_steps;

    assign state_o = state;

    als_seq_fsm #(.STEP_W(STEP_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .pwr_on_i       (pwr_on_i),
        .als_en_i       (als_en_i),
        .wait_en_i      (wait_en_i),
        .sleep_on_int_i (sleep_on_int_i),
        .long_wait_i    (long_wait_i),
        .integ_steps_i  (integ_steps_i),
        .wait_steps_i   (wait_steps_i),
        .int_hit_i      (int_hit_i),
        .bus_start_i    (bus_start_i),
        .expire_i       (expire),
        .state_o        (state),
        .run_o          (run),
        .load_o         (load),
        .load_steps_o   (load_steps),
        .load_long_o    (load_long),
        .adc_start_o    (adc_start_o),
        .done_o         (integ_done_o),
        .latch_o        (latch_o),
        .int_o          (int_o)
    );

    als_step_timer #(.STEP_W(STEP_W), .LONG_MULT(LONG_MULT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (!pwr_on_i),
        .load_i   (load),
        .steps_i  (load_steps),
        .long_i   (load_long),
        .run_i    (run),
        .tick_i   (tick_i),
        .expire_o (expire)
    );

endmodule

// File: tb/als_cycle_seq_tb_top.sv
// Scoreboard bench: driver tasks queue the expected state changes and the
// monitor compares each observed change and its strobes against the queue.
module als_cycle_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int st;
        int dur;
        bit chk_dur;
        bit latch;
        bit intr;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       pwr_on_i = 1'b0, als_en_i = 1'b0, wait_en_i = 1'b0;
    logic       sleep_on_int_i = 1'b0, long_wait_i = 1'b0;
    logic [7:0] integ_steps_i = 8'd1, wait_steps_i = 8'd1;
    logic       int_hit_i = 1'b0, bus_start_i = 1'b0;
    logic [2:0] state_o;
    logic       adc_start_o, integ_done_o, latch_o, int_o;

    int   n_chk = 0, n_fail = 0, pending = 0, tick_cnt = 0, entry_tick = 0;
    int   last_st = 0;
    bit   div = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    als_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pwr_on_i(pwr_on_i),
        .als_en_i(als_en_i), .wait_en_i(wait_en_i), .sleep_on_int_i(sleep_on_int_i),
        .long_wait_i(long_wait_i), .integ_steps_i(integ_steps_i),
        .wait_steps_i(wait_steps_i), .int_hit_i(int_hit_i), .bus_start_i(bus_start_i),
        .state_o(state_o), .adc_start_o(adc_start_o), .integ_done_o(integ_done_o),
        .latch_o(latch_o), .int_o(int_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input int st, input int dur, input bit cd, input bit l, input bit i, input string tag);
        exp_t e;
        e.st = st; e.dur = dur; e.chk_dur = cd; e.latch = l; e.intr = i; e.tag = tag;
        exp_q.push_back(e);
        pending++;
    endtask

    task automatic drain();
        wait (pending == 0);
    endtask

    // Tick source: one-cycle pulse every second cycle, driven on the falling edge.
    always @(negedge clk) begin
        div = ~div;
        tick_i <= rst_n && div;
    end

    // Tick counter used to time each phase.
    always @(posedge clk) if (tick_i) tick_cnt++;

    // Monitor: on every state change pop one expected item and compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(state_o) != last_st) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "unexpected change", int'(state_o), last_st);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(state_o) == e.st, {e.tag, " state"}, int'(state_o), e.st);
                    if (e.chk_dur)
                        chk(tick_cnt - entry_tick == e.dur, {e.tag, " ticks"}, tick_cnt - entry_tick, e.dur);
                    chk(latch_o == e.latch && integ_done_o == e.latch, {e.tag, " R5 latch/done"}, int'(latch_o), int'(e.latch));
                    chk(int_o == e.intr, {e.tag, " R5 int"}, int'(int_o), int'(e.intr));
                    chk(adc_start_o == (e.st == 3), {e.tag, " R4 adc_start"}, int'(adc_start_o), int'(e.st == 3));
                    pending--;
                end
                last_st = int'(state_o);
                entry_tick = tick_cnt;
            end else if (latch_o || int_o || adc_start_o || integ_done_o) begin
                chk(1'b0, "R5 stray strobe", 1, 0);
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", pending, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(state_o == 3'd0, "R1 reset state", int'(state_o), 0);
        chk(!(adc_start_o || latch_o || int_o || integ_done_o), "R1 strobes low", 1, 0);

        // R2: power on leaves Sleep for Idle
        pwr_on_i = 1'b1;
        push(1, 0, 0, 0, 0, "R2 wake");
        drain();

        // R3/R4/R6: no pause, 3-step integration
        integ_steps_i = 8'd3;
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        push(2, 3, 1, 1, 0, "R4 integ3 R6 no pause");
        push(3, 1, 1, 0, 0, "R3 init again");
        drain();
        als_en_i = 1'b0;
        push(1, 3, 1, 1, 0, "R9 stop at integ end");
        drain();

        // R6/R7: short pause of 2 steps
        integ_steps_i = 8'd2; wait_steps_i = 8'd2; wait_en_i = 1'b1;
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        push(4, 2, 1, 1, 0, "R6 integ->pause");
        push(2, 2, 1, 0, 0, "R7 short pause");
        push(3, 1, 1, 0, 0, "R3 init");
        drain();
        als_en_i = 1'b0;
        push(1, 2, 1, 1, 0, "R9 idle over pause");
        drain();

        // R7: long pause of 1 step = 12 ticks
        integ_steps_i = 8'd1; wait_steps_i = 8'd1; long_wait_i = 1'b1;
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        push(4, 1, 1, 1, 0, "R4 integ1");
        push(2, 12, 1, 0, 0, "R7 long pause x12");
        push(3, 1, 1, 0, 0, "R3 init");
        drain();
        als_en_i = 1'b0;
        push(1, 1, 1, 1, 0, "R9 stop");
        drain();

        // R4/R7: zero fields mean 256 steps
        integ_steps_i = 8'd0; wait_steps_i = 8'd0;
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        push(4, 256, 1, 1, 0, "R4 integ 0=256");
        push(2, 3072, 1, 0, 0, "R7 long pause 0=256x12");
        push(3, 1, 1, 0, 0, "R3 init");
        drain();
        als_en_i = 1'b0;
        push(1, 256, 1, 1, 0, "R9 stop");
        drain();

        // R9: disable during pause and during init
        long_wait_i = 1'b0; integ_steps_i = 8'd1; wait_steps_i = 8'd3;
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        push(4, 1, 1, 1, 0, "R6 to pause");
        drain();
        als_en_i = 1'b0;
        push(1, 3, 1, 0, 0, "R9 pause end");
        drain();
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        drain();
        als_en_i = 1'b0;
        push(1, 1, 1, 0, 0, "R9 init end");
        drain();

        // R5: interrupt without park continues the cycle
        wait_en_i = 1'b0; integ_steps_i = 8'd2; int_hit_i = 1'b1;
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        push(2, 2, 1, 1, 1, "R5 int no park");
        push(3, 1, 1, 0, 0, "R3 init");
        drain();
        als_en_i = 1'b0;
        push(1, 2, 1, 1, 1, "R5 int at stop");
        drain();

        // R8: interrupt park, held until bus start
        sleep_on_int_i = 1'b1;
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        push(0, 2, 1, 1, 1, "R8 park");
        drain();
        int_hit_i = 1'b0; sleep_on_int_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(state_o == 3'd0, "R8 stays parked", int'(state_o), 0);
        push(1, 0, 0, 0, 0, "R8 bus start wake");
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        bus_start_i = 1'b1;
        @(negedge clk);
        bus_start_i = 1'b0;
        drain();
        als_en_i = 1'b0;
        push(1, 2, 1, 1, 0, "R9 stop");
        drain();

        // R2: power drop mid-integration forces Sleep, timers restart clean
        als_en_i = 1'b1;
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R3 init");
        drain();
        pwr_on_i = 1'b0;
        push(0, 0, 0, 0, 0, "R2 power drop");
        @(negedge clk);
        chk(state_o == 3'd0, "R2 sleep next cycle", int'(state_o), 0);
        repeat (6) @(negedge clk);
        pwr_on_i = 1'b1;
        push(1, 0, 0, 0, 0, "R2 wake");
        push(2, 0, 0, 0, 0, "R3 idle->init");
        push(3, 1, 1, 0, 0, "R2 init after clear");
        drain();
        als_en_i = 1'b0;
        push(1, 2, 1, 1, 0, "R2 full integ after clear");
        drain();

        repeat (10) @(negedge clk);
        chk(state_o == 3'd1, "R9 idle holds", int'(state_o), 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule